// File: doc/BRIEF.md
# Bus Cycle Termination Classifier

This block watches the termination inputs of an asynchronous-style bus cycle and decides how that cycle ended. Its inputs are a two-bit size acknowledge, an autovector acknowledge, a bus-error line, a halt line and a strobe that is high while a cycle is open. From these it reports one of four outcomes: a normal completion, a halted completion, a bus error, or a retry. A retry is the case where halt and bus error meet. The outcome depends on the order in which the exception lines arrive relative to the acknowledge, not only on which lines are active. A halt seen in any earlier sample of the cycle is therefore remembered until the acknowledge arrives.

The result is a registered one-hot code with a one-cycle done pulse. It also carries the port-size code that the acknowledge carried. The result stays in place for the rest of the cycle and clears once the strobe drops. An optional synchronizer can be placed in front of the sampling logic, and the retry outcome can be switched off by parameter. Both choices are made at elaboration.

Top module: `bus_term_classifier`

## Requirements
- R1: A deciding sample with an acknowledge (size acknowledge not 00, or autovector high), with bus error low and halt low in that sample and in every earlier sample of the cycle, yields the normal result.
- R2: A deciding sample with an acknowledge and bus error low yields the halt result when halt is high in that sample or was high in any earlier sample of the same cycle.
- R3: Bus error high with no halt in the cycle ends the cycle on that sample, with or without an acknowledge, and yields the bus-error result.
- R4: With retry enabled (default), a bus error in a cycle that has also seen halt, in the same sample or earlier, yields the retry result instead of the bus-error result.
- R5: While neither an acknowledge nor a bus error has arrived, the cycle stays open: done stays low and the result stays zero, whatever halt does.
- R6: The port-size output takes the size-acknowledge code of the deciding sample: 01 means 16-bit, 10 means 8-bit, 11 means 16-bit fast, and 00 means no size (autovector only or bus error alone).
- R7: With no synchronizer stages, the result and done appear in the clock cycle after the rising edge that samples the deciding inputs. Done is high for exactly that one cycle.
- R8: Once decided, the result holds while the strobe stays high, and further termination inputs have no effect. A sample with the strobe low clears the result and the remembered halt, so the next cycle starts fresh.
- R9: During reset the result, done and port-size outputs are all zero.
- R10: Result bit 0 is normal, bit 1 is halt, bit 2 is bus error and bit 3 is retry. At most one bit is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_active | input | 1 | High while a bus cycle is open |
| size_ack | input | 2 | Size acknowledge code |
| avec_ack | input | 1 | Autovector acknowledge |
| bus_err | input | 1 | Bus error request |
| bus_halt | input | 1 | Halt request |
| term_result | output | 4 | One-hot outcome (bit map in R10) |
| port_size | output | 2 | Size code of the deciding sample |
| term_done | output | 1 | One-cycle pulse when the outcome is registered |

## Verification
With no synchronizer stages, every decision is due one clock after the edge that samples it. The bench drives each input pattern on a falling edge and reads the outputs on the next falling edge, which falls exactly in the cycle where result, done and size must appear. Holding and clearing are each checked one falling edge after the sample that should cause them. The sweep covers every combination of acknowledge, autovector, bus error and halt, each with and without a halt in the earlier sample.

// File: rtl/bterm_pkg.sv
package bterm_pkg;

   localparam int ACK_W   = 2;
   localparam int RES_W   = 4;
   localparam int RES_NRM = 0;
   localparam int RES_HLT = 1;
   localparam int RES_BER = 2;
   localparam int RES_RTY = 3;

   typedef enum logic [ACK_W-1:0] {
      SZ_NONE = 2'b00,
      SZ_16   = 2'b01,
      SZ_8    = 2'b10,
      SZ_16F  = 2'b11
   } port_size_e;

   typedef struct packed {
      logic             strobe;
      logic [ACK_W-1:0] ack;
      logic             avec;
      logic             berr;
      logic             halt;
   } term_in_t;

   localparam int TERM_IN_W = $bits(term_in_t);

endpackage

// File: rtl/bterm_sync.sv
module bterm_sync
   import bterm_pkg::*;
#(
   parameter int STAGES = 0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  term_in_t d_i,
   output term_in_t q_o
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q_o = d_i;
      end else begin : g_pipe
         term_in_t pipe [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/bterm_order.sv
module bterm_order
   import bterm_pkg::*;
#(
   parameter bit RETRY_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  term_in_t         smp,
   input  logic             armed,
   output logic             decide,
   output logic [RES_W-1:0] cls,
   output logic [ACK_W-1:0] size
);

   logic halt_seen;
   logic ack_any;
   logic halt_any;
   logic retry_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         halt_seen <= 1'b0;
      else if (!smp.strobe)               halt_seen <= 1'b0;
      else if (armed && smp.halt)         halt_seen <= 1'b1;
   end

   generate
      if (RETRY_EN) begin : g_retry
         assign retry_ok = 1'b1;
      end else begin : g_no_retry
         assign retry_ok = 1'b0;
      end
   endgenerate

   assign ack_any  = (|smp.ack) | smp.avec;
   assign halt_any = halt_seen | smp.halt;
   assign decide   = smp.strobe & armed & (ack_any | smp.berr);
   assign size     = smp.ack;

   always_comb begin
      cls = '0;
      if (smp.berr && halt_any && retry_ok) cls[RES_RTY] = 1'b1;
      else if (smp.berr)                    cls[RES_BER] = 1'b1;
      else if (halt_any)                    cls[RES_HLT] = 1'b1;
      else                                  cls[RES_NRM] = 1'b1;
   end

endmodule

// File: rtl/bterm_hold.sv
module bterm_hold
   import bterm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             decide,
   input  logic [RES_W-1:0] cls,
   input  logic [ACK_W-1:0] size,
   output logic             armed,
   output logic [RES_W-1:0] result,
   output logic [ACK_W-1:0] size_q,
   output logic             done
);

   logic decided;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         decided <= 1'b0;
         result  <= '0;
         size_q  <= '0;
         done    <= 1'b0;
      end else begin
         done <= decide;
         if (!strobe) begin
            decided <= 1'b0;
            result  <= '0;
            size_q  <= '0;
         end else if (decide) begin
            decided <= 1'b1;
            result  <= cls;
            size_q  <= size;
         end
      end
   end

   assign armed = ~decided;

endmodule

// File: rtl/bus_term_classifier.sv
module bus_term_classifier
   import bterm_pkg::*;
#(
   parameter int SYNC_STAGES = 0,
   parameter bit RETRY_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cyc_active,
   input  logic [ACK_W-1:0] size_ack,
   input  logic             avec_ack,
   input  logic             bus_err,
   input  logic             bus_halt,
   output logic [RES_W-1:0] term_result,
   output logic [ACK_W-1:0] port_size,
   output logic             term_done
);

   localparam int MAX_SYNC = 4;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("SYNC_STAGES out of range");
      end
   endgenerate

   term_in_t         raw_in;
   term_in_t         smp;
   logic             armed;
   logic             decide;
   logic [RES_W-1:0] cls;
   logic [ACK_W-1:0] size;

   assign raw_in = '{strobe: cyc_active, ack: size_ack, avec: avec_ack,
                     berr: bus_err, halt: bus_halt};

   bterm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (smp)
   );

   bterm_order #(.RETRY_EN(RETRY_EN)) u_order (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp    (smp),
      .armed  (armed),
      .decide (decide),
      .cls    (cls),
      .size   (size)
   );

   bterm_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (smp.strobe),
      .decide (decide),
      .cls    (cls),
      .size   (size),
      .armed  (armed),
      .result (term_result),
      .size_q (port_size),
      .done   (term_done)
   );

endmodule

// File: rtl/bterm_chk.sv
module bterm_chk
   import bterm_pkg::*;
#(
   parameter int SYNC_STAGES = 0,
   parameter bit RETRY_EN    = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cyc_active,
   input logic [ACK_W-1:0] size_ack,
   input logic             avec_ack,
   input logic             bus_err,
   input logic             bus_halt,
   input logic [RES_W-1:0] term_result,
   input logic [ACK_W-1:0] port_size,
   input logic             term_done
);

   p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(term_result));

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      term_done |=> !term_done);

   p_done_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
      term_done |-> ($countones(term_result) == 1));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (term_result != '0) |=> (term_result == '0 || $stable(term_result)));

   generate
      if (SYNC_STAGES == 0) begin : g_direct_chk
         p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !cyc_active |=> (term_result == '0 && !term_done));

         p_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_active && !bus_err && size_ack == '0 && !avec_ack) |=> !term_done);

         p_normal_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (term_done && term_result[RES_NRM]) |-> (!$past(bus_err) && !$past(bus_halt)));

         p_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (term_done && term_result[RES_HLT]) |->
               (!$past(bus_err) && ($past(size_ack) != '0 || $past(avec_ack))));

         p_berr_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (term_done && term_result[RES_BER]) |-> $past(bus_err));

         p_retry_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (term_done && term_result[RES_RTY]) |-> $past(bus_err));

         p_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
            term_done |-> (port_size == $past(size_ack)));
      end
   endgenerate

endmodule

bind bus_term_classifier bterm_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .RETRY_EN    (RETRY_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_active  (cyc_active),
   .size_ack    (size_ack),
   .avec_ack    (avec_ack),
   .bus_err     (bus_err),
   .bus_halt    (bus_halt),
   .term_result (term_result),
   .port_size   (port_size),
   .term_done   (term_done)
);

// File: tb/bus_term_classifier_tb.sv
module bus_term_classifier_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_active = 1'b0;
   logic [1:0] size_ack = 2'b00;
   logic       avec_ack = 1'b0;
   logic       bus_err = 1'b0;
   logic       bus_halt = 1'b0;
   logic [3:0] term_result;
   logic [1:0] port_size;
   logic       term_done;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   bus_term_classifier u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .cyc_active  (cyc_active),
      .size_ack    (size_ack),
      .avec_ack    (avec_ack),
      .bus_err     (bus_err),
      .bus_halt    (bus_halt),
      .term_result (term_result),
      .port_size   (port_size),
      .term_done   (term_done)
   );

   task automatic check(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // drive on a falling edge, then wait one falling edge so the rising edge in between samples
   task automatic apply(input logic stb, input logic [1:0] ack, input logic av,
                        input logic be, input logic ht);
      cyc_active = stb;
      size_ack   = ack;
      avec_ack   = av;
      bus_err    = be;
      bus_halt   = ht;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL R7 watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9", "result in reset", {4'h0, term_result}, 8'h00);
      check("R9", "done in reset", {7'h0, term_done}, 8'h00);
      check("R9", "size in reset", {6'h0, port_size}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      for (int e = 1; e >= 0; e--) begin
         for (int c = 0; c < 32; c++) begin
            logic [1:0] ack;
            logic av, be, ht, hs, dec;
            logic [3:0] exp;
            string req;
            ack = c[4:3];
            av  = c[2];
            be  = c[1];
            ht  = c[0];
            if (e == 1) begin
               apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
               check("R5", "early halt done", {7'h0, term_done}, 8'h00);
               check("R5", "early halt result", {4'h0, term_result}, 8'h00);
            end
            hs  = (e == 1) || ht;
            dec = (ack != 2'b00) || av || be;
            if (!dec)          begin exp = 4'b0000; req = "R5"; end
            else if (be && hs) begin exp = 4'b1000; req = "R4"; end
            else if (be)       begin exp = 4'b0100; req = "R3"; end
            else if (hs)       begin exp = 4'b0010; req = "R2"; end
            else               begin exp = 4'b0001; req = "R1"; end
            apply(1'b1, ack, av, be, ht);
            check(req, "result bits (R10)", {4'h0, term_result}, {4'h0, exp});
            check("R7", "done after deciding sample", {7'h0, term_done}, {7'h0, dec});
            if (dec) begin
               check("R6", "port size", {6'h0, port_size}, {6'h0, ack});
               apply(1'b1, 2'b11, 1'b1, 1'b1, 1'b1);
               check("R8", "held result", {4'h0, term_result}, {4'h0, exp});
               check("R7", "done one cycle", {7'h0, term_done}, 8'h00);
               check("R8", "held size", {6'h0, port_size}, {6'h0, ack});
            end
            apply(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
            check("R8", "cleared result", {4'h0, term_result}, 8'h00);
            check("R8", "cleared done", {7'h0, term_done}, 8'h00);
         end
      end

      // R8: halt from an abandoned cycle must not reach the next one
      apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
      apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
      check("R5", "halt then idle", {4'h0, term_result}, 8'h00);
      apply(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      apply(1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
      check("R8", "fresh cycle after halt", {4'h0, term_result}, 8'h01);
      check("R6", "8-bit size", {6'h0, port_size}, 8'h02);

      // R2: halt two samples before the acknowledge
      apply(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
      apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b1);
      apply(1'b1, 2'b00, 1'b0, 1'b0, 1'b0);
      apply(1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
      check("R2", "remembered halt", {4'h0, term_result}, 8'h02);
      apply(1'b0, 2'b00, 1'b0, 1'b0, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule